// File: doc/BRIEF.md
# Extended Timestamp Timebase with Wrap-Granular Alarm

This block turns a narrow hardware down-counter into a wide, never-wrapping timestamp. A down-counter of `CNT_W` bits (24 by default) advances on each cycle in which the fast tick enable is high, and the tick enable runs at eight times the timestamp rate. The counter always reloads to all ones, so one period is exactly 2^`CNT_W` ticks. A separate wrap counter counts every underflow. The timestamp is the wrap count with the elapsed part of the current period appended below it. The elapsed part is all ones minus the live count. This value is then shifted right by `SHIFT` bits (3 by default, which divides by 8). Both parts come from registers that are updated on the same edge, so the value is always consistent.

There is one alarm slot. A client first asks for it with an allocate request. Only the first request is granted. The client then arms the slot with a target timestamp. Arming keeps only the index of the period in which the target falls. The alarm is evaluated only at underflows. It fires on the first underflow after which the wrap count exceeds that index, so the timestamp is already at or beyond the target when the pulse appears. The cost is that the pulse may come up to one full period late.

Top module: `wrap_timebase`

## Requirements
- R1: While reset is asserted and right after it is released, `now_ts` is 0, and `alloc_grant` and `alarm_fire` are 0.
- R2: After each clock edge that samples `tick_en` high, `now_ts` equals the total number of sampled ticks since reset shifted right by `SHIFT`. Edges that sample `tick_en` low leave `now_ts` unchanged.
- R3: When a tick arrives at count zero, the counter reloads to all ones and the wrap count increases by one. `now_ts` never decreases.
- R4: The first `alloc_req` after reset gets a one-cycle `alloc_grant` in the cycle after the request. Every later request gets no grant.
- R5: An `arm_stb` given before the slot has been granted is ignored, and no `alarm_fire` ever results from it.
- R6: Arming stores the index `arm_target >> (CNT_W - SHIFT)`. `alarm_fire` pulses for one cycle in the cycle after the underflow edge whose new wrap count is greater than that index. In that cycle `now_ts >= arm_target`.
- R7: Firing disarms the slot, and no further pulse occurs until the slot is armed again.
- R8: Arming with a target that is already in the past fires at the very next underflow.
- R9: Arming while an alarm is pending replaces it. Only the new target produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Fast tick enable (8x the timestamp rate) |
| alloc_req | input | 1 | Request for the single alarm slot |
| arm_stb | input | 1 | Arm the slot with `arm_target` |
| arm_target | input | TS_W | Alarm target timestamp |
| now_ts | output | TS_W | Extended monotonic timestamp |
| alloc_grant | output | 1 | One-cycle grant of the alarm slot |
| alarm_fire | output | 1 | One-cycle alarm pulse |

## Verification
A wrong fine count or a missed wrap increment shows in `now_ts` on the very next edge. The bench compares that edge against its own tick tally in every cycle, so a timestamp that stalls, steps back or jumps is caught within one cycle. A wrong alarm index or a bad disarm moves the pulse by a whole period or repeats it. That appears only at the next underflow, so the bench tracks the period in which each pulse is due and flags a late, missing or extra pulse. Slot ownership errors appear as a stray grant on a repeated request, or as a pulse from an arm that should have been ignored.

// File: rtl/wtb_pkg.sv
package wtb_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_IDLE  = 2'd1,
        SLOT_ARMED = 2'd2
    } slot_e;
endpackage

// File: rtl/wtb_downcount.sv
module wtb_downcount #(
    parameter int CNT_W  = 24,
    parameter int WRAP_W = 43
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [WRAP_W-1:0] wraps_q,
    output logic              underflow
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [WRAP_W-1:0] wraps;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    assign underflow = tick_en && (s_q.cnt == '0);

    always_comb begin
        s_d = s_q;
        if (underflow) begin
            s_d.cnt   = '1;
            s_d.wraps = s_q.wraps + WRAP_W'(1);
        end else if (tick_en) begin
            s_d.cnt = s_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt   <= '1;
            s_q.wraps <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_q   = s_q.cnt;
    assign wraps_q = s_q.wraps;

    // R3: underflow reloads and advances the wrap count
    a_r3_reload_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> (cnt_q == '1) && (wraps_q == $past(wraps_q) + WRAP_W'(1)));

    // R2: no tick, no movement
    a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt_q) && $stable(wraps_q));
endmodule

// File: rtl/wtb_alarm.sv
module wtb_alarm
    import wtb_pkg::*;
#(
    parameter int WRAP_W = 43
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic              arm_stb,
    input  logic [WRAP_W-1:0] arm_idx,
    input  logic              underflow,
    input  logic [WRAP_W-1:0] wraps_q,
    output logic              alloc_grant,
    output logic              alarm_fire
);
    typedef struct packed {
        slot_e             slot;
        logic [WRAP_W-1:0] idx;
        logic              grant;
        logic              fire;
    } alarm_state_t;

    alarm_state_t a_d, a_q;
    logic [WRAP_W-1:0] wrap_after;

    assign wrap_after = wraps_q + WRAP_W'(1);

    always_comb begin
        a_d       = a_q;
        a_d.grant = 1'b0;
        a_d.fire  = 1'b0;
        if (alloc_req && (a_q.slot == SLOT_FREE)) begin
            a_d.slot  = SLOT_IDLE;
            a_d.grant = 1'b1;
        end
        if (arm_stb && (a_q.slot != SLOT_FREE)) begin
            a_d.slot = SLOT_ARMED;
            a_d.idx  = arm_idx;
        end else if ((a_q.slot == SLOT_ARMED) && underflow && (wrap_after > a_q.idx)) begin
            a_d.slot = SLOT_IDLE;
            a_d.fire = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q.slot  <= SLOT_FREE;
            a_q.idx   <= '0;
            a_q.grant <= 1'b0;
            a_q.fire  <= 1'b0;
        end else begin
            a_q <= a_d;
        end
    end

    assign alloc_grant = a_q.grant;
    assign alarm_fire  = a_q.fire;

    logic granted_before_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           granted_before_q <= 1'b0;
        else if (alloc_grant) granted_before_q <= 1'b1;
    end

    // R4: at most one grant after reset
    a_r4_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_grant |-> !granted_before_q);

    // R7: a pulse lasts one cycle
    a_r7_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_fire |=> !alarm_fire);

    // R5: no pulse without an owner
    a_r5_needs_owner: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_fire |-> granted_before_q);
endmodule

// File: rtl/wrap_timebase.sv
module wrap_timebase #(
    parameter int CNT_W = 24,
    parameter int SHIFT = 3,
    parameter int TS_W  = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic            alloc_req,
    input  logic            arm_stb,
    input  logic [TS_W-1:0] arm_target,
    output logic [TS_W-1:0] now_ts,
    output logic            alloc_grant,
    output logic            alarm_fire
);
    localparam int WRAP_W    = TS_W + SHIFT - CNT_W;
    localparam int IDX_SHIFT = CNT_W - SHIFT;
    localparam int FULL_W    = WRAP_W + CNT_W;

    logic [CNT_W-1:0]  cnt_q;
    logic [WRAP_W-1:0] wraps_q;
    logic              underflow;
    logic [FULL_W-1:0] full_ticks;

    wtb_downcount #(.CNT_W(CNT_W), .WRAP_W(WRAP_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .cnt_q     (cnt_q),
        .wraps_q   (wraps_q),
        .underflow (underflow)
    );

    // wrap count and elapsed fine ticks come from the same register edge
    assign full_ticks = {wraps_q, ~cnt_q};
    assign now_ts     = full_ticks[FULL_W-1:SHIFT];

    wtb_alarm #(.WRAP_W(WRAP_W)) u_alarm (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_req   (alloc_req),
        .arm_stb     (arm_stb),
        .arm_idx     (arm_target[TS_W-1:IDX_SHIFT]),
        .underflow   (underflow),
        .wraps_q     (wraps_q),
        .alloc_grant (alloc_grant),
        .alarm_fire  (alarm_fire)
    );

    // checker shadow of the last accepted target
    logic            owned_q;
    logic [TS_W-1:0] tgt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owned_q <= 1'b0;
            tgt_q   <= '0;
        end else begin
            if (alloc_grant) owned_q <= 1'b1;
            if (arm_stb && (owned_q || alloc_grant)) tgt_q <= arm_target;
        end
    end

    // R3: the timestamp never steps back
    a_r3_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> now_ts >= $past(now_ts));

    // R6: the target has been reached when the pulse appears
    a_r6_fire_after_target: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_fire |-> now_ts >= tgt_q);
endmodule

// File: tb/wrap_timebase_test.sv
`timescale 1ns/1ps
module wrap_timebase_test;
    localparam int CW = 8;
    localparam int SH = 3;
    localparam int TW = 64;
    localparam int PER_SH = CW;
    localparam int IDX_SH = CW - SH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic alloc_req = 1'b0;
    logic arm_stb = 1'b0;
    logic [TW-1:0] arm_target = '0;
    logic [TW-1:0] now_ts;
    logic alloc_grant, alarm_fire;

    wrap_timebase #(.CNT_W(CW), .SHIFT(SH), .TS_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .alloc_req(alloc_req),
        .arm_stb(arm_stb), .arm_target(arm_target), .now_ts(now_ts),
        .alloc_grant(alloc_grant), .alarm_fire(alarm_fire)
    );

    always #2.5 clk = ~clk;

    int compared = 0;
    int mismatched = 0;
    int fires_seen = 0;
    bit mon_en = 1'b0;
    bit gap_mode = 1'b0;
    bit done = 1'b0;
    longint unsigned mticks = 0;

    typedef struct { longint unsigned wrap; longint unsigned target; } fire_item_t;
    fire_item_t exp_q[$];

    task automatic check(input bit ok, input string req, input longint unsigned act,
                         input longint unsigned expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // reference tally of sampled ticks
    always @(posedge clk) begin
        if (!rst_n) mticks = 0;
        else if (tick_en) mticks = mticks + 1;
    end

    // tick driver, optionally every other cycle
    always @(negedge clk) begin
        if (!rst_n) tick_en = 1'b0;
        else if (gap_mode) tick_en = ~tick_en;
        else tick_en = 1'b1;
    end

    // monitor: timestamp every cycle, alarm pulses against the scoreboard
    always @(negedge clk) begin
        if (mon_en) begin
            longint unsigned cur_w;
            check(now_ts == (mticks >> SH), "R2 timestamp", now_ts, mticks >> SH);
            cur_w = mticks >> PER_SH;
            if (alarm_fire) begin
                fires_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5/R7 unexpected pulse", 1, 0);
                end else begin
                    fire_item_t it;
                    it = exp_q.pop_front();
                    check(cur_w == it.wrap, "R6 pulse period", cur_w, it.wrap);
                    check(now_ts >= it.target, "R6 ts at pulse", now_ts, it.target);
                end
            end else if (exp_q.size() != 0 && cur_w > exp_q[0].wrap) begin
                check(1'b0, "R6 missed pulse", cur_w, exp_q[0].wrap);
                void'(exp_q.pop_front());
            end
        end
    end

    task automatic do_alloc(input bit expect_grant, input string req);
        @(negedge clk); alloc_req = 1'b1;
        @(negedge clk); alloc_req = 1'b0;
        check(alloc_grant == expect_grant, req, alloc_grant, expect_grant);
        @(negedge clk);
        check(alloc_grant == 1'b0, "R4 grant one cycle", alloc_grant, 0);
    endtask

    task automatic do_arm(input longint unsigned t, input bit accepted);
        @(negedge clk); arm_stb = 1'b1; arm_target = t;
        @(posedge clk); #1;
        arm_stb = 1'b0;
        if (accepted) begin
            longint unsigned w, idx, fw;
            fire_item_t it;
            w = mticks >> PER_SH;
            idx = t >> IDX_SH;
            fw = (idx + 1 > w + 1) ? idx + 1 : w + 1;
            exp_q.delete();
            it.wrap = fw; it.target = t;
            exp_q.push_back(it);
        end
    endtask

    task automatic drain(input int extra_periods);
        int guard = 0;
        while (exp_q.size() != 0 && guard < 20000) begin
            @(negedge clk); guard++;
        end
        repeat (extra_periods * (1 << PER_SH) * 2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check(now_ts == 0, "R1 ts in reset", now_ts, 0);
        check(alloc_grant == 0, "R1 grant in reset", alloc_grant, 0);
        check(alarm_fire == 0, "R1 fire in reset", alarm_fire, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(now_ts == 0, "R1 ts after reset", now_ts, 0);
        mon_en = 1'b1;

        // R5: arm before ownership is ignored
        do_arm(64'd10, 1'b0);
        drain(3);

        // R4: one grant only
        do_alloc(1'b1, "R4 first request granted");
        do_alloc(1'b0, "R4 second request refused");
        do_alloc(1'b0, "R4 third request refused");

        // R6: future target
        do_arm((mticks >> SH) + 200, 1'b1);
        drain(0);
        // R7: disarmed after the pulse
        drain(3);

        // R8: past target fires at the next underflow
        do_arm(64'd0, 1'b1);
        drain(1);

        // R9: replacement of a pending alarm
        do_arm((mticks >> SH) + 2000, 1'b1);
        repeat (10) @(negedge clk);
        do_arm((mticks >> SH) + 40, 1'b1);
        drain(0);
        repeat (2500 * 8 / 4) @(negedge clk);

        // R2: sparse ticks with an alarm in flight
        gap_mode = 1'b1;
        do_arm((mticks >> SH) + 300, 1'b1);
        drain(2);
        gap_mode = 1'b0;
        drain(1);

        check(fires_seen == 4, "R6 pulse count", fires_seen, 4);
        check(exp_q.size() == 0, "R6 nothing pending", exp_q.size(), 0);
        done = 1'b1;
        mon_en = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(190000 * 5);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule